// File: doc/BRIEF.md
# Transmit Stuff Decision Unit

This block decides, once per outgoing line frame, whether four stuff bits are added to that frame. It measures the phase between two frame references in system clock cycles. A counter restarts on each PCM frame marker, and its value is taken when the next line frame marker arrives. The block compares that phase with a programmable threshold and issues a stuff request of zero or four bits, marked by a one-cycle valid pulse.

The threshold is the number of clock cycles that make up eight line bit times. If the phase is at or above the threshold, four bits are requested. A smaller phase requests none. A line marker that arrives without a PCM marker since the previous line marker counts as a negative phase. That means the clock or frame tolerance has been exceeded, so the block requests no stuffing and sets a sticky error flag.

Three 10-bit thresholds can be written through a byte-wide register port, each one split into a low byte and a high byte. The thresholds for twelve and twenty-four bit times are stored and read back only. A status byte carries the error flag, and reading that byte clears the flag.

Top module: `stuff_decider`

## Requirements
- R1: After reset, stuff_vld and stuff_err are 0 and the thresholds read back as their reset values: A = 64, B = 96, C = 192.
- R2: The register map is BASE_ADDR + offset, with BASE_ADDR = 0xCF. Threshold A uses offsets 0 (low) and 1 (high), B uses offsets 2 and 3, C uses offsets 4 and 5, and status uses offset 6. A low byte holds threshold bits 7:0. Bits 1:0 of a high byte hold threshold bits 9:8, and bits 7:2 of a high byte always read 0. reg_rdata is combinational from reg_addr, and unmapped addresses read 0.
- R3: The phase is the number of rising clock edges from the edge that samples pcm_mark to the edge that samples line_mark. Every pcm_mark restarts the measurement.
- R4: When line_mark is sampled with a non-negative phase that is at least threshold A, stuff_cnt = 4 together with stuff_vld on the next cycle.
- R5: When line_mark is sampled with a non-negative phase below threshold A, stuff_cnt = 0 together with stuff_vld on the next cycle.
- R6: When line_mark is sampled and no pcm_mark has been sampled since the previous line_mark, the phase is negative. stuff_cnt is then 0 with stuff_vld, and stuff_err is 1 on the next cycle.
- R7: When pcm_mark and line_mark are sampled on the same edge, the phase is zero and counts as non-negative: no error, and 4 bits are requested only if threshold A is 0. That pcm_mark is used up by this line_mark.
- R8: stuff_err is sticky. It clears on the cycle after err_clr is sampled, or after a reg_rd of the status byte (bit 0 = error). A new error on the same edge wins over a clear.
- R9: Thresholds B and C are stored and read back but do not change the stuff decision.
- R10: stuff_vld is high for exactly one cycle per sampled line_mark, and stuff_cnt is 0 whenever stuff_vld is low.
- R11: The phase counter saturates at 2^CNT_W-1 (65535 by default) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that the phase is counted in |
| rst_n | input | 1 | Asynchronous active-low reset |
| pcm_mark | input | 1 | One-cycle PCM frame reference |
| line_mark | input | 1 | One-cycle line frame reference |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of the status byte clears the error |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| err_clr | input | 1 | Explicit clear of the error flag |
| stuff_vld | output | 1 | One-cycle pulse carrying the decision for a line frame |
| stuff_cnt | output | 3 | Stuff bits requested: 0 or 4 |
| stuff_err | output | 1 | Sticky flag for a negative phase |

## Verification
The main function is tried with phases one below, equal to, and well above threshold A. These separate the comparison from an off-by-one error in the counter or the compare. A PCM marker that arrives again partway through a frame shows whether the counter restarts. Coincident markers and a line marker with no PCM marker since the previous one separate the zero-phase case from the negative-phase case. A frame longer than the counter range shows whether the counter saturates or wraps, and changes to thresholds B and C show that they have no effect on the decision.

// File: rtl/stuff_pkg.sv
`timescale 1ns/1ps
package stuff_pkg;
  localparam int unsigned THR_W   = 10;
  localparam int unsigned NTHR    = 3;
  localparam int unsigned STUFF_W = 3;
  localparam int unsigned HI_W    = THR_W - 8;

  localparam logic [STUFF_W-1:0] STUFF_NONE = 3'd0;
  localparam logic [STUFF_W-1:0] STUFF_FOUR = 3'd4;

  localparam logic [7:0] OFF_STAT = 8'd6;

  typedef logic [THR_W-1:0] thr_t;

  typedef struct packed {
    logic               vld;
    logic [STUFF_W-1:0] cnt;
  } stuff_req_t;

  function automatic logic [7:0] lo_off(input int idx);
    return 8'(2 * idx);
  endfunction

  function automatic logic [7:0] hi_off(input int idx);
    return 8'(2 * idx + 1);
  endfunction
endpackage

// File: rtl/stuff_thr_regs.sv
`timescale 1ns/1ps
module stuff_thr_regs
  import stuff_pkg::*;
#(
  parameter logic [7:0]            BASE_ADDR = 8'hCF,
  parameter logic [NTHR*THR_W-1:0] RST_VALS  = '0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  input  logic       err_flag,
  output logic [7:0] rdata,
  output thr_t       thr_a,
  output logic       stat_rd
);
  localparam logic [7:0] STAT_ADDR = BASE_ADDR + OFF_STAT;

  thr_t            thr_q [NTHR];
  thr_t            thr_d [NTHR];
  logic [NTHR-1:0] thr_en;

  // next state
  always_comb begin
    for (int i = 0; i < NTHR; i++) begin
      thr_d[i]  = thr_q[i];
      thr_en[i] = 1'b0;
      if (wr_en && (addr == BASE_ADDR + lo_off(i))) begin
        thr_d[i][7:0] = wdata;
        thr_en[i]     = 1'b1;
      end
      if (wr_en && (addr == BASE_ADDR + hi_off(i))) begin
        thr_d[i][THR_W-1:8] = wdata[HI_W-1:0];
        thr_en[i]           = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTHR; i++) thr_q[i] <= RST_VALS[i*THR_W +: THR_W];
    end else begin
      for (int i = 0; i < NTHR; i++) begin
        if (thr_en[i]) thr_q[i] <= thr_d[i];
      end
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NTHR; i++) begin
      if (addr == BASE_ADDR + lo_off(i)) rdata = thr_q[i][7:0];
      if (addr == BASE_ADDR + hi_off(i)) rdata = {{(8-HI_W){1'b0}}, thr_q[i][THR_W-1:8]};
    end
    if (addr == STAT_ADDR) rdata = {7'b0, err_flag};
  end

  assign stat_rd = rd_en && (addr == STAT_ADDR);
  assign thr_a   = thr_q[0];
endmodule

// File: rtl/stuff_phase_meas.sv
`timescale 1ns/1ps
module stuff_phase_meas #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pcm_mark,
  input  logic             line_mark,
  output logic [CNT_W-1:0] smp_phase,
  output logic             smp_neg,
  output logic             armed
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             armed_q, armed_d, armed_en;

  // next state
  always_comb begin
    cnt_en   = pcm_mark || (cnt_q != CNT_MAX);
    cnt_d    = pcm_mark ? CNT_ONE : cnt_q + CNT_ONE;
    armed_en = pcm_mark || line_mark;
    armed_d  = !line_mark;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (cnt_en)   cnt_q   <= cnt_d;
      if (armed_en) armed_q <= armed_d;
    end
  end

  // sample presented to the judge on a line marker
  always_comb begin
    smp_phase = pcm_mark ? '0 : cnt_q;
    smp_neg   = !(armed_q || pcm_mark);
  end

  assign armed = armed_q;
endmodule

// File: rtl/stuff_judge.sv
`timescale 1ns/1ps
module stuff_judge
  import stuff_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_mark,
  input  logic [CNT_W-1:0]   smp_phase,
  input  logic               smp_neg,
  input  thr_t               thr_a,
  input  logic               err_clr,
  input  logic               stat_rd,
  output logic               stuff_vld,
  output logic [STUFF_W-1:0] stuff_cnt,
  output logic               stuff_err
);
  stuff_req_t req_q, req_d;
  logic       reach;
  logic       err_q, err_d, err_en, err_set;

  // next state
  always_comb begin
    reach     = !smp_neg && (smp_phase >= CNT_W'(thr_a));
    req_d.vld = line_mark;
    req_d.cnt = (line_mark && reach) ? STUFF_FOUR : STUFF_NONE;
    err_set   = line_mark && smp_neg;
    err_en    = err_set || err_clr || stat_rd;
    err_d     = err_set;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      err_q <= 1'b0;
    end else begin
      req_q <= req_d;
      if (err_en) err_q <= err_d;
    end
  end

  assign stuff_vld = req_q.vld;
  assign stuff_cnt = req_q.cnt;
  assign stuff_err = err_q;
endmodule

// File: rtl/stuff_decider.sv
`timescale 1ns/1ps
module stuff_decider
  import stuff_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter logic [7:0]  BASE_ADDR = 8'hCF,
  parameter thr_t        THR_A_RST = 10'd64,
  parameter thr_t        THR_B_RST = 10'd96,
  parameter thr_t        THR_C_RST = 10'd192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pcm_mark,
  input  logic       line_mark,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       err_clr,
  output logic       stuff_vld,
  output logic [2:0] stuff_cnt,
  output logic       stuff_err
);
  localparam logic [NTHR*THR_W-1:0] RST_VALS = {THR_C_RST, THR_B_RST, THR_A_RST};

  logic [CNT_W-1:0] smp_phase;
  logic             smp_neg;
  logic             meas_armed;
  thr_t             thr_a;
  logic             stat_rd;

  stuff_phase_meas #(.CNT_W(CNT_W)) meas_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pcm_mark  (pcm_mark),
    .line_mark (line_mark),
    .smp_phase (smp_phase),
    .smp_neg   (smp_neg),
    .armed     (meas_armed)
  );

  stuff_thr_regs #(.BASE_ADDR(BASE_ADDR), .RST_VALS(RST_VALS)) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .rd_en    (reg_rd),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .err_flag (stuff_err),
    .rdata    (reg_rdata),
    .thr_a    (thr_a),
    .stat_rd  (stat_rd)
  );

  stuff_judge #(.CNT_W(CNT_W)) judge_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_mark (line_mark),
    .smp_phase (smp_phase),
    .smp_neg   (smp_neg),
    .thr_a     (thr_a),
    .err_clr   (err_clr),
    .stat_rd   (stat_rd),
    .stuff_vld (stuff_vld),
    .stuff_cnt (stuff_cnt),
    .stuff_err (stuff_err)
  );
endmodule

// File: rtl/stuff_decider_chk.sv
`timescale 1ns/1ps
module stuff_decider_chk #(
  parameter logic [7:0] BASE_ADDR = 8'hCF
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pcm_mark,
  input logic       line_mark,
  input logic       reg_rd,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_rdata,
  input logic       err_clr,
  input logic       stuff_vld,
  input logic [2:0] stuff_cnt,
  input logic       stuff_err,
  input logic       meas_armed
);
  localparam logic [7:0] STAT_ADDR = BASE_ADDR + 8'd6;

  assert_vld_follows_mark_R10: assert property (@(posedge clk) disable iff (!rst_n)
    line_mark |=> stuff_vld);

  assert_no_vld_without_mark_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !line_mark |=> !stuff_vld);

  assert_cnt_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !stuff_vld |-> (stuff_cnt == 3'd0));

  assert_cnt_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_vld |-> (stuff_cnt == 3'd0 || stuff_cnt == 3'd4));

  assert_neg_sets_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_mark && !pcm_mark && !meas_armed) |=> (stuff_err && stuff_cnt == 3'd0));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stuff_err && !err_clr && !(reg_rd && reg_addr == STAT_ADDR)) |=> stuff_err);

  assert_err_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !line_mark) |=> !stuff_err);

  assert_hi_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == BASE_ADDR + 8'd1 || reg_addr == BASE_ADDR + 8'd3 ||
     reg_addr == BASE_ADDR + 8'd5) |-> (reg_rdata[7:2] == 6'd0));
endmodule

bind stuff_decider stuff_decider_chk #(.BASE_ADDR(BASE_ADDR)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .pcm_mark   (pcm_mark),
  .line_mark  (line_mark),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .err_clr    (err_clr),
  .stuff_vld  (stuff_vld),
  .stuff_cnt  (stuff_cnt),
  .stuff_err  (stuff_err),
  .meas_armed (meas_armed)
);

// File: tb/stuff_decider_tb_top.sv
`timescale 1ns/1ps
module stuff_decider_tb_top;
  localparam int CNT_MAX = 65535;
  localparam logic [7:0] A_LO = 8'hCF, A_HI = 8'hD0, B_LO = 8'hD1, B_HI = 8'hD2;
  localparam logic [7:0] C_LO = 8'hD3, C_HI = 8'hD4, STAT = 8'hD5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pcm_mark = 1'b0, line_mark = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, err_clr = 1'b0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       stuff_vld, stuff_err;
  logic [2:0] stuff_cnt;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stuff_decider dut_i (
    .clk(clk), .rst_n(rst_n), .pcm_mark(pcm_mark), .line_mark(line_mark),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .err_clr(err_clr), .stuff_vld(stuff_vld),
    .stuff_cnt(stuff_cnt), .stuff_err(stuff_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_thr [3];
  int m_cnt;
  bit m_armed;
  bit e_vld, e_err;
  int e_cnt;
  int m_ph;
  bit m_ok;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_thr[0] <= 64; m_thr[1] <= 96; m_thr[2] <= 192;
      m_cnt <= 0; m_armed <= 0; e_vld <= 0; e_err <= 0; e_cnt <= 0;
    end else begin
      m_ok = m_armed || pcm_mark;
      m_ph = pcm_mark ? 0 : m_cnt;
      e_vld <= line_mark;
      e_cnt <= (line_mark && m_ok && m_ph >= m_thr[0]) ? 4 : 0;
      if (line_mark && !m_ok) e_err <= 1;
      else if (err_clr || (reg_rd && reg_addr == STAT)) e_err <= 0;
      if (line_mark) m_armed <= 0;
      else if (pcm_mark) m_armed <= 1;
      if (pcm_mark) m_cnt <= 1;
      else if (m_cnt < CNT_MAX) m_cnt <= m_cnt + 1;
      if (reg_wr) begin
        for (int i = 0; i < 3; i++) begin
          if (reg_addr == A_LO + 8'(2*i)) m_thr[i] <= (m_thr[i] & 32'h300) | int'(reg_wdata);
          if (reg_addr == A_LO + 8'(2*i+1)) m_thr[i] <= (m_thr[i] & 32'hFF) | (int'(reg_wdata[1:0]) << 8);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(stuff_vld == e_vld, "R10 model stuff_vld", int'(stuff_vld), int'(e_vld));
      chk(int'(stuff_cnt) == e_cnt, "R4/R5 model stuff_cnt", int'(stuff_cnt), e_cnt);
      chk(stuff_err == e_err, "R6/R8 model stuff_err", int'(stuff_err), int'(e_err));
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input int exp, input string tag);
    reg_addr = a; reg_rd = 1'b1;
    #1;
    chk(int'(reg_rdata) == exp, tag, int'(reg_rdata), exp);
    tick();
    reg_rd = 1'b0;
  endtask

  task automatic set_a(input int v);
    wr(A_LO, 8'(v & 255));
    wr(A_HI, 8'(v >> 8));
  endtask

  // pcm marker, then line marker k edges later; check decision
  task automatic frame(input int k, input int exp, input string tag);
    pcm_mark = 1'b1;
    tick();
    pcm_mark = 1'b0;
    repeat (k - 1) tick();
    line_mark = 1'b1;
    @(negedge clk);
    chk(stuff_vld && int'(stuff_cnt) == exp, tag, int'(stuff_cnt), exp);
    #1 line_mark = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(!stuff_vld && !stuff_err, "R1 outputs after reset", int'(stuff_vld | stuff_err), 0);
    rd(A_LO, 64, "R1 thr A reset");
    rd(B_LO, 96, "R1 thr B reset");
    rd(C_LO, 192, "R1 thr C reset");
    rd(C_HI, 0, "R1 thr C hi reset");
    rd(STAT, 0, "R1 status reset");

    // R2 register map and high-byte width
    wr(A_HI, 8'hFF);
    rd(A_HI, 3, "R2 hi upper bits read zero");
    rd(A_LO, 64, "R2 lo unaffected by hi write");
    set_a(100);
    rd(A_LO, 100, "R2 thr A lo");
    rd(A_HI, 0, "R2 thr A hi");
    rd(8'hE0, 0, "R2 unmapped reads zero");

    // R4 / R5 boundaries around threshold A = 100
    frame(150, 4, "R4 phase above threshold");
    frame(100, 4, "R4 phase equal threshold");
    frame(99, 0, "R5 phase one below threshold");
    frame(10, 0, "R5 short phase");

    // R3 restart of the measurement
    pcm_mark = 1'b1; tick(); pcm_mark = 1'b0;
    repeat (200) tick();
    frame(50, 0, "R3 pcm marker restarts phase");

    // R6 negative phase and R8 stickiness / read clear
    line_mark = 1'b1;
    @(negedge clk);
    chk(stuff_err && stuff_vld && stuff_cnt == 3'd0, "R6 lone line marker", int'(stuff_err), 1);
    #1 line_mark = 1'b0;
    repeat (5) tick();
    chk(stuff_err == 1'b1, "R8 error sticky", int'(stuff_err), 1);
    rd(STAT, 1, "R8 status shows error");
    chk(stuff_err == 1'b0, "R8 read clears error", int'(stuff_err), 0);

    // R8 explicit clear, and set wins over clear
    line_mark = 1'b1; tick(); line_mark = 1'b0;
    err_clr = 1'b1; tick(); err_clr = 1'b0;
    chk(stuff_err == 1'b0, "R8 err_clr clears", int'(stuff_err), 0);
    line_mark = 1'b1; err_clr = 1'b1;
    @(negedge clk);
    chk(stuff_err == 1'b1, "R8 set wins over clear", int'(stuff_err), 1);
    #1 line_mark = 1'b0; err_clr = 1'b0;
    err_clr = 1'b1; tick(); err_clr = 1'b0;

    // R7 coincident markers
    pcm_mark = 1'b1; line_mark = 1'b1;
    @(negedge clk);
    chk(stuff_vld && stuff_cnt == 3'd0 && !stuff_err, "R7 zero phase below thr", int'(stuff_cnt), 0);
    #1 pcm_mark = 1'b0; line_mark = 1'b0;
    set_a(0);
    pcm_mark = 1'b1; line_mark = 1'b1;
    @(negedge clk);
    chk(stuff_vld && stuff_cnt == 3'd4 && !stuff_err, "R7 zero phase with thr 0", int'(stuff_cnt), 4);
    #1 pcm_mark = 1'b0; line_mark = 1'b0;
    repeat (3) tick();
    line_mark = 1'b1;
    @(negedge clk);
    chk(stuff_err == 1'b1, "R7 coincident pcm marker used up", int'(stuff_err), 1);
    #1 line_mark = 1'b0;
    err_clr = 1'b1; tick(); err_clr = 1'b0;

    // R9 thresholds B and C do not steer the decision
    set_a(100);
    wr(B_LO, 8'h00); wr(B_HI, 8'h00); wr(C_LO, 8'h00); wr(C_HI, 8'h00);
    frame(50, 0, "R9 low B/C no effect");
    wr(B_LO, 8'hFF); wr(B_HI, 8'h03); wr(C_LO, 8'hFF); wr(C_HI, 8'h03);
    frame(150, 4, "R9 high B/C no effect");
    rd(B_HI, 3, "R9 thr B readback");
    rd(C_LO, 255, "R9 thr C readback");

    // R10 no pulse without line marker
    repeat (4) tick();
    chk(!stuff_vld && stuff_cnt == 3'd0, "R10 idle outputs", int'(stuff_vld), 0);

    // R11 counter saturation (wrap would give 500 < 1023)
    set_a(1023);
    frame(65536 + 500, 4, "R11 counter saturates");

    repeat (3) tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule